// File: doc/BRIEF.md
# Multi-Write-Port Register File

This block is a small register file with several independent write ports and several independent read ports. It is made only from storage banks that each accept a single write per cycle, which is the form block memories take. Each write port owns one bank. A flip-flop table, indexed by address, records which write port stored the newest value at each address. On a read, that table chooses which bank supplies the data. Callers see ordinary multi-port register-file behaviour.

Each write port's bank is copied once for every read port, so each read port has its own path. Reads are synchronous and take one cycle. The file suits datapaths that retire several results per cycle, such as an instruction that writes two destination registers. It also suits wide-issue pipelines. The entry count, data width, read-port count and write-port count are all parameters.

Top module: `mwrf_regfile`

## Requirements
- R1: After synchronous reset, every address reads as zero on every read port until it is written.
- R2: A write on any port to address A is returned by a read of A that is presented in a later cycle. Read data appears on the output one clock after the read address is presented.
- R3: Data written through any single write port can be read on every read port.
- R4: When different write ports write the same address in different cycles, later reads return the value from the most recent of those writes.
- R5: When several write ports write the same address in the same cycle, the highest-numbered of those ports wins. Port index 0 is the lowest priority.
- R6: A read presented in the same cycle as a write to the same address returns the value that address held before that write.
- R7: A write port whose enable bit is 0 changes no stored value, whatever its address and data inputs carry.
- R8: Each read port returns data for its own address, independently of the addresses on the other read ports in the same cycle.
- R9: A write to one address leaves the contents of every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | N_WR | Write enable, bit w belongs to write port w |
| wr_addr | input | N_WR*AW | Write addresses, port w in bits [w*AW +: AW] |
| wr_data | input | N_WR*WIDTH | Write data, port w in bits [w*WIDTH +: WIDTH] |
| rd_addr | input | N_RD*AW | Read addresses, port r in bits [r*AW +: AW] |
| rd_data | output | N_RD*WIDTH | Read data, port r in bits [r*WIDTH +: WIDTH], valid one cycle after its address |

## Verification
The embedded assertions check four things on every cycle:
- Each bank holds the data written to it on the cycle after the write.
- The live-value table only ever names an existing write port.
- The table points at the highest-numbered port after that port writes.
- All outputs are zero on the cycle after reset is released.

Some behaviour depends on a full history of writes and cannot be shown by a single property. This covers ordering between ports over time, the old-value rule for a write and read in the same cycle, ignored disabled writes, and the absence of disturbance to other addresses. The bench's scoreboard scenarios, compared against a reference array, show these.

// File: rtl/mwrf_pkg.sv
package mwrf_pkg;

    // Default geometry of the register file.
    localparam int DEF_DEPTH = 8;
    localparam int DEF_WIDTH = 16;
    localparam int DEF_N_RD  = 6;
    localparam int DEF_N_WR  = 5;

    // Number of bits needed to index n items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/mwrf_bank.sv
module mwrf_bank #(
    parameter int DEPTH = mwrf_pkg::DEF_DEPTH,
    parameter int WIDTH = mwrf_pkg::DEF_WIDTH,
    localparam int AW   = mwrf_pkg::idx_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    // Single write port, registered single read port (old data on collision).
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (we) begin
                mem[waddr] <= wdata;
            end
            rdata <= mem[raddr];
        end
    end

    AST_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> mem[$past(waddr)] == $past(wdata)); // R2

endmodule

// File: rtl/mwrf_lvt.sv
module mwrf_lvt #(
    parameter int DEPTH = mwrf_pkg::DEF_DEPTH,
    parameter int N_RD  = mwrf_pkg::DEF_N_RD,
    parameter int N_WR  = mwrf_pkg::DEF_N_WR,
    localparam int AW   = mwrf_pkg::idx_bits(DEPTH),
    localparam int SW   = mwrf_pkg::idx_bits(N_WR)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_WR-1:0]    we,
    input  logic [N_WR*AW-1:0] waddr,
    input  logic [N_RD*AW-1:0] raddr,
    output logic [N_RD*SW-1:0] sel_q
);

    logic [SW-1:0] owner [DEPTH];

    // Ports applied in ascending order: the highest enabled port is the last
    // nonblocking assignment to a shared address and therefore wins.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                owner[i] <= '0;
            end
        end else begin
            for (int w = 0; w < N_WR; w++) begin
                if (we[w]) begin
                    owner[waddr[w*AW +: AW]] <= SW'(w);
                end
            end
        end
    end

    // Registered lookup, aligned with the registered bank reads.
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else begin
            for (int r = 0; r < N_RD; r++) begin
                sel_q[r*SW +: SW] <= owner[raddr[r*AW +: AW]];
            end
        end
    end

    generate
        for (genvar r = 0; r < N_RD; r++) begin : g_range
            AST_LVT_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
                int'(sel_q[r*SW +: SW]) < N_WR); // R4
        end
    endgenerate

    AST_LVT_HIGH_PORT_WINS: assert property (@(posedge clk) disable iff (rst)
        we[N_WR-1] |=> owner[$past(waddr[(N_WR-1)*AW +: AW])] == SW'(N_WR-1)); // R5

endmodule

// File: rtl/mwrf_regfile.sv
module mwrf_regfile #(
    parameter int DEPTH = mwrf_pkg::DEF_DEPTH,
    parameter int WIDTH = mwrf_pkg::DEF_WIDTH,
    parameter int N_RD  = mwrf_pkg::DEF_N_RD,
    parameter int N_WR  = mwrf_pkg::DEF_N_WR,
    localparam int AW   = mwrf_pkg::idx_bits(DEPTH),
    localparam int SW   = mwrf_pkg::idx_bits(N_WR)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N_WR-1:0]       wr_en,
    input  logic [N_WR*AW-1:0]    wr_addr,
    input  logic [N_WR*WIDTH-1:0] wr_data,
    input  logic [N_RD*AW-1:0]    rd_addr,
    output logic [N_RD*WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] bank_q [N_WR][N_RD];
    logic [N_RD*SW-1:0] sel_q;

    // One bank per (write port, read port) pair.
    generate
        for (genvar w = 0; w < N_WR; w++) begin : g_wr
            for (genvar r = 0; r < N_RD; r++) begin : g_rd
                mwrf_bank #(
                    .DEPTH (DEPTH),
                    .WIDTH (WIDTH)
                ) u_bank (
                    .clk   (clk),
                    .rst   (rst),
                    .we    (wr_en[w]),
                    .waddr (wr_addr[w*AW +: AW]),
                    .wdata (wr_data[w*WIDTH +: WIDTH]),
                    .raddr (rd_addr[r*AW +: AW]),
                    .rdata (bank_q[w][r])
                );
            end
        end
    endgenerate

    mwrf_lvt #(
        .DEPTH (DEPTH),
        .N_RD  (N_RD),
        .N_WR  (N_WR)
    ) u_lvt (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .waddr (wr_addr),
        .raddr (rd_addr),
        .sel_q (sel_q)
    );

    // Steer each read port to the bank the table names.
    always_comb begin
        rd_data = '0;
        for (int r = 0; r < N_RD; r++) begin
            for (int w = 0; w < N_WR; w++) begin
                if (sel_q[r*SW +: SW] == SW'(w)) begin
                    rd_data[r*WIDTH +: WIDTH] = bank_q[w][r];
                end
            end
        end
    end

    AST_RESET_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> rd_data == '0); // R1

endmodule

// File: tb/mwrf_regfile_test.sv
`timescale 1ns/1ps
module mwrf_regfile_test;

    localparam int DEPTH = 8;
    localparam int WIDTH = 16;
    localparam int N_RD  = 6;
    localparam int N_WR  = 5;
    localparam int AW    = $clog2(DEPTH);

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [N_WR-1:0]       wr_en;
    logic [N_WR*AW-1:0]    wr_addr;
    logic [N_WR*WIDTH-1:0] wr_data;
    logic [N_RD*AW-1:0]    rd_addr;
    logic [N_RD*WIDTH-1:0] rd_data;

    always #2.5 clk = ~clk;

    mwrf_regfile #(
        .DEPTH (DEPTH), .WIDTH (WIDTH), .N_RD (N_RD), .N_WR (N_WR)
    ) uut (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_data (rd_data)
    );

    logic             t_we [N_WR];
    logic [AW-1:0]    t_wa [N_WR];
    logic [WIDTH-1:0] t_wd [N_WR];
    logic [AW-1:0]    t_ra [N_RD];

    always_comb begin
        for (int w = 0; w < N_WR; w++) begin
            wr_en[w]                   = t_we[w];
            wr_addr[w*AW +: AW]        = t_wa[w];
            wr_data[w*WIDTH +: WIDTH]  = t_wd[w];
        end
        for (int r = 0; r < N_RD; r++) begin
            rd_addr[r*AW +: AW] = t_ra[r];
        end
    end

    logic [WIDTH-1:0] ref_mem [DEPTH];
    int    cyc = 0;
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    int               q_stamp [$];
    int               q_port  [$];
    logic [WIDTH-1:0] q_exp   [$];
    string            q_req   [$];

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compare results of the cycle that just completed.
    always @(negedge clk) begin
        while (q_stamp.size() > 0 && q_stamp[0] == cyc - 1) begin
            automatic int p = q_port.pop_front();
            automatic logic [WIDTH-1:0] e = q_exp.pop_front();
            automatic string rq = q_req.pop_front();
            automatic logic [WIDTH-1:0] a = rd_data[p*WIDTH +: WIDTH];
            void'(q_stamp.pop_front());
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s read port %0d: actual %h expected %h", rq, p, a, e);
            end
        end
    end

    task automatic clear_writes();
        for (int w = 0; w < N_WR; w++) begin
            t_we[w] = 1'b0;
            t_wa[w] = '0;
            t_wd[w] = '0;
        end
    endtask

    // Driver: push expected reads from the model (old data), update model
    // with enabled writes in ascending port order, then advance one cycle.
    task automatic step(input string req);
        for (int r = 0; r < N_RD; r++) begin
            q_stamp.push_back(cyc);
            q_port.push_back(r);
            q_exp.push_back(ref_mem[t_ra[r]]);
            q_req.push_back(req);
        end
        for (int w = 0; w < N_WR; w++) begin
            if (t_we[w]) ref_mem[t_wa[w]] = t_wd[w];
        end
        @(negedge clk);
        clear_writes();
    endtask

    task automatic read_all(input logic [AW-1:0] a, input string req);
        for (int r = 0; r < N_RD; r++) t_ra[r] = a;
        step(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
        clear_writes();
        for (int r = 0; r < N_RD; r++) t_ra[r] = '0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: every address reads zero after reset
        for (int r = 0; r < N_RD; r++) t_ra[r] = AW'(r);
        step("R1");
        for (int r = 0; r < N_RD; r++) t_ra[r] = AW'(DEPTH - 1 - r);
        step("R1");

        // R2/R3: port 0 writes, all ports read it next cycle
        t_we[0] = 1'b1; t_wa[0] = 3; t_wd[0] = 16'h1111;
        read_all(0, "R2");
        read_all(3, "R3");

        // R4: port 4 writes then port 1 overwrites
        t_we[4] = 1'b1; t_wa[4] = 5; t_wd[4] = 16'hAAAA;
        read_all(5, "R4");
        read_all(5, "R4");
        t_we[1] = 1'b1; t_wa[1] = 5; t_wd[1] = 16'hBBBB;
        read_all(0, "R4");
        read_all(5, "R4");

        // R5: all ports collide on address 6, port 4 must win
        for (int w = 0; w < N_WR; w++) begin
            t_we[w] = 1'b1; t_wa[w] = 6; t_wd[w] = WIDTH'(16'h5000 + w);
        end
        read_all(1, "R5");
        read_all(6, "R5");
        // R5: ports 1 and 2 collide on address 0, port 2 must win
        t_we[1] = 1'b1; t_wa[1] = 0; t_wd[1] = 16'h0101;
        t_we[2] = 1'b1; t_wa[2] = 0; t_wd[2] = 16'h0202;
        read_all(2, "R5");
        read_all(0, "R5");

        // R6: read while writing same address returns old value
        t_we[2] = 1'b1; t_wa[2] = 1; t_wd[2] = 16'hCCCC;
        read_all(1, "R6");
        read_all(1, "R6");

        // R7: disabled write has no effect
        for (int w = 0; w < N_WR; w++) begin
            t_we[w] = 1'b0; t_wa[w] = 3; t_wd[w] = 16'hDEAD;
        end
        read_all(3, "R7");
        read_all(3, "R7");

        // R8: distinct addresses on each read port
        for (int r = 0; r < N_RD; r++) t_ra[r] = AW'((r * 3 + 1) % DEPTH);
        step("R8");
        for (int r = 0; r < N_RD; r++) t_ra[r] = AW'((r + 5) % DEPTH);
        step("R8");

        // R9: rotating writes, reads sweep all addresses
        for (int k = 0; k < 12; k++) begin
            for (int w = 0; w < N_WR; w++) begin
                t_we[w] = ((k + w) % 3) != 0;
                t_wa[w] = AW'((k + w * 2) % DEPTH);
                t_wd[w] = WIDTH'(k * 97 + w * 13 + 1);
            end
            for (int r = 0; r < N_RD; r++) t_ra[r] = AW'((k + r) % DEPTH);
            step("R9");
        end
        for (int a = 0; a < DEPTH; a++) begin
            for (int r = 0; r < N_RD; r++) t_ra[r] = AW'(a);
            step("R9");
        end

        repeat (3) @(negedge clk);
        if (q_stamp.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", q_stamp.size());
        end
        finish_run();
    end

endmodule